// File: doc/BRIEF.md
# Real-Time Clock Interrupt Status Register

This block holds the interrupt status of a real-time clock. Three single-cycle event pulses come in from the rest of the clock: a periodic tick, an alarm match and the end of an update cycle. Each pulse sets its own sticky flag. The flag is set whatever its interrupt enable is. Three enable levels come from the clock's control register. A summary flag is raised whenever a set flag has its enable set, and the active-low interrupt pin follows the summary flag.

A host reaches two registers through a strobed port with a 4-bit address and 8-bit data. A read of the status register returns the flags as they stood before the read and clears them all. An event that arrives in the same cycle as the clearing read is kept. The second register reports whether the clock contents are valid, from the battery-low input, and holds a small read/write field.

Top module: `rtc_irq_status`

## Requirements
- R1: While `rst_n` is low, all three event flags clear. After reset, `irq_n` is 1 and a status read returns 0x00.
- R2: A pulse on an event input sets its flag on the next clock edge, whether or not its enable is set. The flag stays set until it is cleared.
- R3: The status register at address 0xC reads as follows: bit 7 is the summary, bit 6 the periodic flag, bit 5 the alarm flag and bit 4 the update-ended flag. The summary is 1 exactly when some flag is 1 together with its enable.
- R4: `irq_n` is 0 exactly when the summary is 1. It follows the flags and enables without a clock, so clearing an enable releases `irq_n` in the same cycle.
- R5: A read strobe to the status register puts the flag values from before the read onto `host_rdata` at the next edge. It clears all three flags at that same edge.
- R6: An event pulse that coincides with a clearing status read leaves its flag set after the read.
- R7: Bits 3:0 of the status register always read 0. Writes to the status register change nothing.
- R8: The validity register sits at address 0xD. Its bit 7 reads 0 while `batt_low` is 1 and reads 1 otherwise. Its bit 6 always reads 0.
- R9: Bits 5:0 of the validity register are a read/write field, cleared by reset. A write to that register ignores data bits 7 and 6.
- R10: `host_rdata` changes only on a read strobe. A read of any other address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-cycle-ended pulse |
| en_periodic | input | 1 | Periodic interrupt enable |
| en_alarm | input | 1 | Alarm interrupt enable |
| en_update | input | 1 | Update-ended interrupt enable |
| batt_low | input | 1 | Battery-low indication |
| host_strobe | input | 1 | One-cycle access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Two functions can meet in one clock cycle: an event pulse setting its flag, and a status read clearing all flags. The bench drives every combination of event pulses on the very cycle of a clearing read. It checks that the read data shows the flags from before the read and that the coinciding events stay latched. A second read follows, and its value must equal exactly the coinciding event set. All 64 pairs of event and enable patterns are also swept, and the summary bit and `irq_n` are compared with the OR of the event and enable patterns ANDed together.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;
    localparam int NUM_EVT = 3;
    localparam int AUX_W   = 6;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 4'hC;
    localparam logic [ADDR_W-1:0] ADDR_VALID  = 4'hD;

    // event index inside the flag vector; status bit = index + 4
    localparam int EV_UPD = 0;
    localparam int EV_ALM = 1;
    localparam int EV_PER = 2;
    localparam int BIT_SUM = 7;
    localparam int BIT_VLD = 7;
endpackage

// File: rtl/rtc_evt_flag.sv
module rtc_evt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // a set on the clearing cycle wins, so no event is lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else
            flag_o <= (flag_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/rtc_aux_field.sv
module rtc_aux_field #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] q_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q_o <= '0;
        else if (wr_i)
            q_o <= wdata_i;
    end
endmodule

// File: rtl/rtc_irq_status.sv
module rtc_irq_status
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_periodic,
    input  logic              evt_alarm,
    input  logic              evt_update,
    input  logic              en_periodic,
    input  logic              en_alarm,
    input  logic              en_update,
    input  logic              batt_low,
    input  logic              host_strobe,
    input  logic              host_write,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              irq_n
);
    localparam int FLAG_LSB = BIT_SUM - NUM_EVT;

    logic [NUM_EVT-1:0] evt_vec, en_vec, flags;
    logic [AUX_W-1:0]   aux_q;
    logic               rd_status, rd_valid, wr_valid, summary;
    logic [DATA_W-1:0]  status_word, valid_word, rd_mux;

    assign evt_vec = {evt_periodic, evt_alarm, evt_update};
    assign en_vec  = {en_periodic, en_alarm, en_update};

    assign rd_status = host_strobe & ~host_write & (host_addr == ADDR_STATUS);
    assign rd_valid  = host_strobe & ~host_write & (host_addr == ADDR_VALID);
    assign wr_valid  = host_strobe &  host_write & (host_addr == ADDR_VALID);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        rtc_evt_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_vec[i]),
            .clr_i (rd_status),
            .flag_o(flags[i])
        );
    end

    rtc_aux_field #(.WIDTH(AUX_W)) u_aux (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (wr_valid),
        .wdata_i(host_wdata[AUX_W-1:0]),
        .q_o    (aux_q)
    );

    assign summary = |(flags & en_vec);
    assign irq_n   = ~summary;

    always_comb begin
        status_word = '0;
        status_word[BIT_SUM] = summary;
        status_word[FLAG_LSB +: NUM_EVT] = flags;
        valid_word = '0;
        valid_word[BIT_VLD] = ~batt_low;
        valid_word[AUX_W-1:0] = aux_q;
        if (rd_status)
            rd_mux = status_word;
        else if (rd_valid)
            rd_mux = valid_word;
        else
            rd_mux = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (host_strobe && !host_write)
            host_rdata <= rd_mux;
    end

    // ---------------- assertions ----------------
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_alarm |=> (host_rdata == host_rdata) && !irq_n || !en_alarm);
    assert_flag_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[EV_PER] && !rd_status) |=> flags[EV_PER]);
    assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && evt_vec == '0) |=> (flags == '0) && irq_n);
    assert_coincide_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && evt_update) |=> flags[EV_UPD]);
    assert_low_nibble_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_status |=> (host_rdata[3:0] == 4'h0));
    assert_battery_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && batt_low) |=> (host_rdata[BIT_VLD] == 1'b0) && (host_rdata[6] == 1'b0));
    assert_no_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_vec == '0) |-> irq_n);
    assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_strobe && !host_write) |=> $stable(host_rdata));
endmodule

// File: tb/rtc_irq_status_test.sv
module rtc_irq_status_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_p = 0, ev_a = 0, ev_u = 0;
    logic en_p = 0, en_a = 0, en_u = 0;
    logic batt_low = 0;
    logic strobe = 0, wr = 0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic irq_n;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    rtc_irq_status uut (
        .clk(clk), .rst_n(rst_n),
        .evt_periodic(ev_p), .evt_alarm(ev_a), .evt_update(ev_u),
        .en_periodic(en_p), .en_alarm(en_a), .en_update(en_u),
        .batt_low(batt_low), .host_strobe(strobe), .host_write(wr),
        .host_addr(addr), .host_wdata(wdata), .host_rdata(rdata), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // ev: {periodic, alarm, update}; events driven during the access cycle
    task automatic access(input logic w, input logic [3:0] a, input logic [7:0] d,
                          input logic [2:0] ev);
        @(negedge clk);
        strobe = 1; wr = w; addr = a; wdata = d;
        {ev_p, ev_a, ev_u} = ev;
        @(negedge clk);
        strobe = 0; wr = 0; {ev_p, ev_a, ev_u} = 3'b000;
    endtask

    task automatic pulse(input logic [2:0] ev);
        @(negedge clk);
        {ev_p, ev_a, ev_u} = ev;
        @(negedge clk);
        {ev_p, ev_a, ev_u} = 3'b000;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 irq_n in reset", {7'b0, irq_n}, 8'h01);
        rst_n = 1;
        access(0, 4'hC, 8'h00, 3'b000);
        check("R1 status after reset", rdata, 8'h00);

        // R2 R3 R4 R5: sweep all event and enable patterns
        for (int e = 0; e < 8; e++) begin
            for (int n = 0; n < 8; n++) begin
                logic [2:0] ev, en;
                logic s;
                ev = e[2:0]; en = n[2:0];
                s = |(ev & en);
                {en_p, en_a, en_u} = en;
                access(0, 4'hC, 8'h00, 3'b000);
                pulse(ev);
                check("R4 irq_n after events", {7'b0, irq_n}, {7'b0, ~s});
                access(0, 4'hC, 8'h00, 3'b000);
                check("R3 status content R2", rdata, {s, ev, 4'b0000});
                access(0, 4'hC, 8'h00, 3'b000);
                check("R5 flags cleared by read", rdata, 8'h00);
            end
        end

        // R4: clearing the enable releases irq_n without a clock edge
        {en_p, en_a, en_u} = 3'b010;
        pulse(3'b010);
        check("R4 irq asserted", {7'b0, irq_n}, 8'h00);
        #1 en_a = 0; #1;
        check("R4 combinational release", {7'b0, irq_n}, 8'h01);
        en_a = 1;

        // R6: events coinciding with the clearing read
        for (int e = 0; e < 8; e++) begin
            logic [2:0] pre, co;
            pre = 3'b101; co = e[2:0];
            {en_p, en_a, en_u} = 3'b111;
            access(0, 4'hC, 8'h00, 3'b000);
            pulse(pre);
            access(0, 4'hC, 8'h00, co);
            check("R6 read shows pre-read flags", rdata, {1'b1, pre, 4'b0});
            access(0, 4'hC, 8'h00, 3'b000);
            check("R6 coinciding events kept", rdata, {|co, co, 4'b0});
        end

        // R7: writes to status ignored
        pulse(3'b011);
        access(1, 4'hC, 8'h00, 3'b000);
        access(0, 4'hC, 8'h00, 3'b000);
        check("R7 status write ignored", rdata, 8'hB0);
        access(1, 4'hC, 8'hFF, 3'b000);
        access(0, 4'hC, 8'h00, 3'b000);
        check("R7 low nibble zero", rdata, 8'h00);

        // R8 R9: validity register
        batt_low = 1;
        access(0, 4'hD, 8'h00, 3'b000);
        check("R8 battery low", rdata, 8'h00);
        batt_low = 0;
        access(0, 4'hD, 8'h00, 3'b000);
        check("R8 battery good", rdata, 8'h80);
        access(1, 4'hD, 8'hFF, 3'b000);
        access(0, 4'hD, 8'h00, 3'b000);
        check("R9 aux write, bits 7:6 ignored", rdata, 8'hBF);
        access(1, 4'hD, 8'h55, 3'b000);
        batt_low = 1;
        access(0, 4'hD, 8'h00, 3'b000);
        check("R9 aux pattern R8", rdata, 8'h15);
        batt_low = 0;

        // R10: other address reads zero, rdata holds without read
        access(0, 4'h3, 8'h00, 3'b000);
        check("R10 other address", rdata, 8'h00);
        access(0, 4'hD, 8'h00, 3'b000);
        pulse(3'b111);
        access(1, 4'hD, 8'h01, 3'b000);
        check("R10 rdata held", rdata, 8'h95);

        // R1: reset clears flags and aux
        #1 rst_n = 0;
        @(negedge clk);
        check("R1 irq_n released by reset", {7'b0, irq_n}, 8'h01);
        rst_n = 1;
        access(0, 4'hC, 8'h00, 3'b000);
        check("R1 flags clear after reset", rdata, 8'h00);
        access(0, 4'hD, 8'h00, 3'b000);
        check("R1 aux clear after reset R9", rdata, 8'h80);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule